// File: doc/BRIEF.md
# Windowed Watchdog Timer with Lockable Setup

This block is a watchdog timer for a system-on-chip. A slow time base reaches it as a one-cycle enable strobe, `slow_en`, in the fast clock domain. A prescaler divides that strobe by a fixed ratio to make a watchdog tick, and a down-counter runs on those ticks. Software writes a setup word once after reset. The setup word gives the reload value, the restart window, the reset-request enable, the debug-freeze enable and a disable bit. After the first write the setup word is frozen until the next reset.

Software keeps the watchdog alive by writing a restart command that carries a fixed key. A restart is only accepted while the count is at or below the window value. A restart that arrives too early is treated as a fault. Reaching zero is also a fault. Each fault sets a sticky status flag and, when enabled, drives a reset request for the system reset controller. A debug-halt input can freeze counting while a debugger holds the processor.

Top module: `wdw_top`

## Requirements
- R1: After reset, the status word reads 0x0FFF0000 (count 0xFFF, no flags) and the setup word reads 0x0FFF1FFF. The setup word layout is: reload in [11:0], reset enable in bit 12, debug-freeze enable in bit 13, disable in bit 15, window in [27:16]. `rst_req` is low.
- R2: Only the first setup write after reset (address 1) takes effect. Every later setup write is ignored, including one that sets the disable bit.
- R3: One watchdog tick happens for every 128 cycles in which `slow_en` is high. The count changes only on a tick or on an accepted restart.
- R4: On each tick, if the watchdog is enabled, not frozen and not at zero, the count drops by one. The status word shows the count in [27:16].
- R5: A restart is a write to address 0 with key 0xA5 in [31:24] and bit 0 set. If the count is at or below the window, the restart reloads the count from the reload field. A window of 0xFFF therefore accepts a restart at any time.
- R6: A write to address 0 with any other key, or with bit 0 clear, has no effect.
- R7: A restart while the count is above the window sets the sticky error flag (status bit 1) and leaves the count unchanged. If reset enable is set, it also raises `rst_req` from the next cycle.
- R8: A tick at count zero does three things: it sets the sticky underflow flag (status bit 0), it reloads the count, and, if reset enable is set, it raises `rst_req` from the next cycle until the following tick.
- R9: With debug-freeze enabled, the count holds while `dbg_halt` is high.
- R10: With the disable bit set, the count holds, restarts are ignored and `rst_req` stays low.
- R11: Reading the status word (address 2) clears both flags in the next cycle. A flag set in that same cycle stays set.
- R12: An accepted restart in the same cycle as a tick takes priority, and that tick does not decrement the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_en | input | 1 | One-cycle strobe from the slow time base |
| dbg_halt | input | 1 | Debugger holds the processor |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 restart, 1 setup, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| rst_req | output | 1 | Reset request to the system reset controller |

## Verification
The assertions assume that every input is synchronous to `clk` and free of unknown values after reset. They also assume at most one register access per cycle, so a restart and a setup write never coincide. The bench drives every input on the falling edge and selects a single operation per cycle (restart, status read, setup write or idle). It strobes `slow_en` and `dbg_halt` at random rates, which lets ticks, freezes, restarts and reads overlap in all combinations while staying within those assumptions.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
   typedef enum logic [1:0] {
      WDW_CTRL = 2'd0,
      WDW_MODE = 2'd1,
      WDW_STAT = 2'd2
   } wdw_addr_e;

   localparam logic [7:0] WDW_KEY     = 8'hA5;
   localparam int         KEY_LSB     = 24;
   localparam int         RESTART_BIT = 0;
   localparam int         RSTEN_BIT   = 12;
   localparam int         HALT_BIT    = 13;
   localparam int         OFF_BIT     = 15;
   localparam int         WIN_LSB     = 16;
   localparam int         ST_UF_BIT   = 0;
   localparam int         ST_ERR_BIT  = 1;
   localparam int         ST_CNT_LSB  = 16;
endpackage

// File: rtl/wdw_prescale.sv
module wdw_prescale #(
   parameter int DIV = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_en,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad
         $error("wdw_prescale: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         assign tick = slow_en;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pc <= '0;
            end else if (slow_en) begin
               pc <= (pc == LAST) ? '0 : pc + PW'(1);
            end
         end
         assign tick = slow_en && (pc == LAST);
      end
   endgenerate
endmodule

// File: rtl/wdw_regs.sv
module wdw_regs
   import wdw_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [1:0]       bus_addr,
   input  logic [31:0]      bus_wdata,
   input  logic             uf_set,
   input  logic             err_set,
   input  logic [CNT_W-1:0] cnt,
   output logic [31:0]      bus_rdata,
   output logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] window,
   output logic             rst_en,
   output logic             halt_en,
   output logic             off,
   output logic             kick,
   output logic             locked,
   output logic             mode_wr
);
   logic uf_q, err_q, stat_rd;
   logic [31:0] mode_view, stat_view;

   assign mode_wr = bus_wr && (bus_addr == WDW_MODE);
   assign stat_rd = bus_rd && (bus_addr == WDW_STAT);
   assign kick    = bus_wr && (bus_addr == WDW_CTRL)
                 && (bus_wdata[KEY_LSB +: 8] == WDW_KEY)
                 && bus_wdata[RESTART_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload  <= '1;
         window  <= '1;
         rst_en  <= 1'b1;
         halt_en <= 1'b0;
         off     <= 1'b0;
         locked  <= 1'b0;
      end else if (mode_wr && !locked) begin
         reload  <= bus_wdata[CNT_W-1:0];
         window  <= bus_wdata[WIN_LSB +: CNT_W];
         rst_en  <= bus_wdata[RSTEN_BIT];
         halt_en <= bus_wdata[HALT_BIT];
         off     <= bus_wdata[OFF_BIT];
         locked  <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uf_q  <= 1'b0;
         err_q <= 1'b0;
      end else begin
         uf_q  <= uf_set  | (uf_q  & ~stat_rd);
         err_q <= err_set | (err_q & ~stat_rd);
      end
   end

   always_comb begin
      mode_view                     = '0;
      mode_view[CNT_W-1:0]          = reload;
      mode_view[WIN_LSB +: CNT_W]   = window;
      mode_view[RSTEN_BIT]          = rst_en;
      mode_view[HALT_BIT]           = halt_en;
      mode_view[OFF_BIT]            = off;
      stat_view                     = '0;
      stat_view[ST_UF_BIT]          = uf_q;
      stat_view[ST_ERR_BIT]         = err_q;
      stat_view[ST_CNT_LSB +: CNT_W] = cnt;
      case (bus_addr)
         WDW_MODE: bus_rdata = mode_view;
         WDW_STAT: bus_rdata = stat_view;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdw_core.sv
module wdw_core #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             kick,
   input  logic             dbg_halt,
   input  logic [CNT_W-1:0] reload,
   input  logic [CNT_W-1:0] window,
   input  logic             rst_en,
   input  logic             halt_en,
   input  logic             off,
   output logic [CNT_W-1:0] cnt,
   output logic             uf_set,
   output logic             err_set,
   output logic             rst_req
);
   logic kick_ok, early, step, at_zero, fault, req_q;

   assign kick_ok = kick && !off;
   assign early   = kick_ok && (cnt > window);
   assign step    = tick && !off && !(halt_en && dbg_halt) && !kick_ok;
   assign at_zero = (cnt == '0);
   assign uf_set  = step && at_zero;
   assign err_set = early;
   assign fault   = (uf_set || err_set) && rst_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '1;
      end else if (kick_ok) begin
         if (!early) cnt <= reload;
      end else if (step) begin
         cnt <= at_zero ? reload : cnt - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     req_q <= 1'b0;
      else if (fault) req_q <= 1'b1;
      else if (tick)  req_q <= 1'b0;
   end

   assign rst_req = req_q && !off;
endmodule

// File: rtl/wdw_top.sv
module wdw_top #(
   parameter int CNT_W    = 12,
   parameter int PRESCALE = 128
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        slow_en,
   input  logic        dbg_halt,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [1:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        rst_req
);
   generate
      if (CNT_W < 2 || CNT_W > 12) begin : g_bad_w
         $error("wdw_top: CNT_W must lie in 2..12");
      end
   endgenerate

   logic             tick, kick, uf_set, err_set;
   logic             rst_en, halt_en, off, locked, mode_wr;
   logic [CNT_W-1:0] cnt, reload, window;

   wdw_prescale #(.DIV(PRESCALE)) u_pre (
      .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .tick(tick)
   );

   wdw_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .uf_set(uf_set),
      .err_set(err_set), .cnt(cnt), .bus_rdata(bus_rdata),
      .reload(reload), .window(window), .rst_en(rst_en),
      .halt_en(halt_en), .off(off), .kick(kick), .locked(locked),
      .mode_wr(mode_wr)
   );

   wdw_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick),
      .dbg_halt(dbg_halt), .reload(reload), .window(window),
      .rst_en(rst_en), .halt_en(halt_en), .off(off), .cnt(cnt),
      .uf_set(uf_set), .err_set(err_set), .rst_req(rst_req)
   );
endmodule

// File: rtl/wdw_chk.sv
module wdw_chk #(
   parameter int CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             kick,
   input logic             dbg_halt,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] reload,
   input logic [CNT_W-1:0] window,
   input logic             rst_en,
   input logic             halt_en,
   input logic             off,
   input logic             locked,
   input logic             mode_wr,
   input logic             rst_req
);
   logic runs;
   assign runs = tick && !kick && !off && !(halt_en && dbg_halt);

   a_r2_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && mode_wr) |=> $stable({reload, window, rst_en, halt_en, off}));

   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !kick) |=> $stable(cnt));

   a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (runs && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

   a_r5_kick_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (kick && !off && cnt <= window) |=> (cnt == $past(reload)));

   a_r7_early_req: assert property (@(posedge clk) disable iff (!rst_n)
      (kick && !off && cnt > window && rst_en) |=> rst_req);

   a_r8_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (runs && cnt == '0) |=> (cnt == $past(reload)) && (rst_req == $past(rst_en)));

   a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_en && dbg_halt && !kick) |=> $stable(cnt));

   a_r10_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
      off |=> $stable(cnt));
endmodule

bind wdw_top wdw_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .dbg_halt(dbg_halt),
   .cnt(cnt), .reload(reload), .window(window), .rst_en(rst_en),
   .halt_en(halt_en), .off(off), .locked(locked), .mode_wr(mode_wr),
   .rst_req(rst_req)
);

// File: tb/wdw_top_bench.sv
`timescale 1ns/1ps
module wdw_top_bench;
   logic        clk = 1'b0;
   logic        rst_n, slow_en, dbg_halt, bus_wr, bus_rd, rst_req;
   logic [1:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata, rd;
   int          total = 0, bad = 0;
   logic        saw_req;

   always #2 clk = ~clk;

   wdw_top u_wdw_top (
      .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .dbg_halt(dbg_halt),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
   );

   // reference state built from the requirements
   int          m_pre;
   logic [11:0] m_cnt, m_reload, m_win;
   logic        m_ren, m_hen, m_off, m_lock, m_req, m_uf, m_err;

   always @(posedge clk) begin : model
      logic tk, kk, early, step, ev, nuf, nerr, clr;
      if (!rst_n) begin
         m_pre <= 0; m_cnt <= 12'hFFF; m_reload <= 12'hFFF; m_win <= 12'hFFF;
         m_ren <= 1'b1; m_hen <= 1'b0; m_off <= 1'b0; m_lock <= 1'b0;
         m_req <= 1'b0; m_uf <= 1'b0; m_err <= 1'b0;
      end else begin
         tk = slow_en && (m_pre == 127);
         if (slow_en) m_pre <= (m_pre == 127) ? 0 : m_pre + 1;
         kk = bus_wr && bus_addr == 2'd0 && bus_wdata[31:24] == 8'hA5
              && bus_wdata[0] && !m_off;
         early = kk && (m_cnt > m_win);
         // R12: an accepted restart swallows a coincident tick
         step = tk && !m_off && !(m_hen && dbg_halt) && !kk;
         ev = 1'b0; nuf = 1'b0; nerr = 1'b0;
         if (kk) begin
            if (early) begin nerr = 1'b1; ev = m_ren; end
            else m_cnt <= m_reload;
         end else if (step) begin
            if (m_cnt == 12'h0) begin nuf = 1'b1; ev = m_ren; m_cnt <= m_reload; end
            else m_cnt <= m_cnt - 12'h1;
         end
         if (ev) m_req <= 1'b1; else if (tk) m_req <= 1'b0;
         clr = bus_rd && bus_addr == 2'd2;
         m_uf  <= nuf  | (m_uf  & ~clr);
         m_err <= nerr | (m_err & ~clr);
         if (bus_wr && bus_addr == 2'd1 && !m_lock) begin
            m_reload <= bus_wdata[11:0]; m_win <= bus_wdata[27:16];
            m_ren <= bus_wdata[12]; m_hen <= bus_wdata[13];
            m_off <= bus_wdata[15]; m_lock <= 1'b1;
         end
      end
   end

   function automatic logic [31:0] exp_status();
      return {4'h0, m_cnt, 14'h0, m_err, m_uf};
   endfunction

   function automatic logic [31:0] exp_mode();
      return {4'h0, m_win, m_off, 1'b0, m_hen, m_ren, m_reload};
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         check("R8 R7 R10 rst_req", {31'h0, rst_req}, {31'h0, m_req && !m_off});
         if (rst_req) saw_req = 1'b1;
      end
   end

   task automatic reset_dut();
      rst_n = 1'b0; slow_en = 1'b0; dbg_halt = 1'b0;
      bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(4 * 190000);
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] c1;
      void'($urandom(32'h5EED1234));
      saw_req = 1'b0;

      // R1 reset state
      reset_dut();
      check("R1 rst_req", {31'h0, rst_req}, 32'h0);
      bus_read(2'd2, rd); check("R1 status", rd, 32'h0FFF0000);
      bus_read(2'd1, rd); check("R1 setup", rd, 32'h0FFF1FFF);

      // R3 / R4 exact prescale ratio
      reset_dut();
      slow_en = 1'b1; repeat (127) @(negedge clk); slow_en = 1'b0;
      bus_read(2'd2, rd); check("R3 127 pulses", rd, 32'h0FFF0000);
      slow_en = 1'b1; @(negedge clk); slow_en = 1'b0;
      bus_read(2'd2, rd); check("R4 128th pulse", rd, 32'h0FFE0000);

      // R2 write-once, R5 restart, R8 underflow, R11 clear on read
      reset_dut();
      bus_write(2'd1, 32'h0FFF1002);
      bus_write(2'd1, 32'h0FFF9FFF);
      bus_read(2'd1, rd); check("R2 setup locked", rd, 32'h0FFF1002);
      bus_write(2'd0, 32'hA5000001);
      bus_read(2'd2, rd); check("R5 restart reload", rd, 32'h00020000);
      saw_req = 1'b0; slow_en = 1'b1;
      wait (m_uf === 1'b1);
      @(negedge clk); slow_en = 1'b0;
      bus_read(2'd2, rd); check("R8 underflow flag", {31'h0, rd[0]}, 32'h1);
      check("R8 request seen", {31'h0, saw_req}, 32'h1);
      bus_read(2'd2, rd); check("R11 flags cleared", {30'h0, rd[1:0]}, 32'h0);

      // R6 wrong key or missing restart bit
      bus_read(2'd2, c1);
      bus_write(2'd0, 32'h5A000001);
      bus_write(2'd0, 32'hA5000000);
      bus_read(2'd2, rd); check("R6 no effect", rd, c1);

      // R7 early restart
      reset_dut();
      bus_write(2'd1, 32'h00101100);
      bus_write(2'd0, 32'hA5000001);
      check("R7 request", {31'h0, rst_req}, 32'h1);
      bus_read(2'd2, rd); check("R7 error kept count", rd, 32'h0FFF0002);

      // R9 debug freeze
      reset_dut();
      bus_write(2'd1, 32'h0FFF3005);
      bus_write(2'd0, 32'hA5000001);
      dbg_halt = 1'b1; slow_en = 1'b1;
      repeat (2000) @(negedge clk);
      slow_en = 1'b0;
      bus_read(2'd2, rd); check("R9 frozen", rd, 32'h00050000);
      dbg_halt = 1'b0;

      // R10 disabled
      reset_dut();
      bus_write(2'd1, 32'h0FFF9003);
      saw_req = 1'b0; slow_en = 1'b1;
      repeat (1000) @(negedge clk);
      bus_write(2'd0, 32'hA5000001);
      slow_en = 1'b0;
      bus_read(2'd2, rd); check("R10 count held", rd, 32'h0FFF0000);
      check("R10 no request", {31'h0, saw_req}, 32'h0);

      // random phase against the reference state
      for (int r = 0; r < 4; r++) begin
         logic [11:0] win;
         reset_dut();
         win = ($urandom % 2) ? 12'hFFF : 12'($urandom % 24);
         bus_write(2'd1, {4'h0, win, 2'b00, 1'($urandom % 2), 1'($urandom % 2),
                          12'($urandom % 4)});
         bus_read(2'd1, rd); check("R2 setup accepted", rd, exp_mode());
         for (int i = 0; i < 12000; i++) begin
            int sel;
            @(negedge clk);
            bus_wr = 1'b0; bus_rd = 1'b0;
            slow_en  = ($urandom % 4) != 0;
            dbg_halt = ($urandom % 6) == 0;
            sel = $urandom % 300;
            if (sel < 1) begin
               bus_wr = 1'b1; bus_addr = 2'd0;
               bus_wdata = {(($urandom % 4) == 0) ? 8'h3C : 8'hA5, 23'h0,
                            1'(($urandom % 8) != 0)};
            end else if (sel < 15) begin
               bus_rd = 1'b1; bus_addr = 2'd2;
               #1 check("R4 R5 R11 R12 status", bus_rdata, exp_status());
            end else if (sel == 15) begin
               bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = $urandom;
            end
         end
         @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
         bus_read(2'd1, rd); check("R2 setup after random", rd, exp_mode());
      end
      finish_run();
   end
endmodule